// File: doc/BRIEF.md
# Dual-Wrap Word Address Counter

This block holds the current word address of a byte-wide serial memory array. A bus front end hands it the two address bytes of a transfer, most significant first, and strobes an advance after each data byte has been acknowledged. The counter then points at the byte the next access will use.

How the counter advances depends on the direction of the transfer. In write mode, only the in-page offset counts, so a long burst circles inside one page. In read mode, the whole address counts and runs off the top of the array back to byte zero.

The value is kept between transfers. A read that skips the address phase therefore starts at the last touched byte plus one. The protocol engine and the array itself sit outside this block.

Top module: `wac_top`

## Requirements
- R1: After reset the address is 0, and no high address byte is waiting.
- R2: A high-byte load stages `byte_in`; of that byte only the low ADDR_W-8 bits (5 by default) are kept and the rest are ignored. A following low-byte load sets the address, one cycle later, to {staged high bits, `byte_in`}.
- R3: With `rd_mode`=0, an advance adds one to the low PAGE_W bits (5 by default) modulo 2^PAGE_W and leaves the upper bits unchanged, so offset 31 wraps to offset 0 of the same page.
- R4: With `rd_mode`=1, an advance adds one to the full address modulo 2^ADDR_W, so 2^ADDR_W-1 wraps to 0.
- R5: In a cycle with no advance and no committing low-byte load, the address holds its value indefinitely.
- R6: A low-byte load is ignored in any of these cases:
  - no high byte has been staged since the last committed low byte;
  - it arrives in the same cycle as a high-byte load.
  A high-byte load by itself leaves the address unchanged.
- R7: A committing low-byte load takes priority over an advance in the same cycle. An advance in the same cycle as a high-byte load still takes effect.
- R8: `page_ofs` always equals the low PAGE_W bits of `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| load_hi | input | 1 | Stage the high address byte from `byte_in` |
| load_lo | input | 1 | Commit the low address byte from `byte_in` |
| byte_in | input | 8 | Address byte from the bus front end |
| step | input | 1 | Advance after an acknowledged data byte |
| rd_mode | input | 1 | 1 = read wrap (whole array), 0 = write wrap (in page) |
| addr | output | ADDR_W | Current word address |
| page_ofs | output | PAGE_W | Offset of `addr` inside its page |

## Verification
The assertions assume that `rd_mode` is meaningful only in cycles where `step` is high. They also assume that nothing is strobed while the internal reset release is still in progress. The stimulus meets both assumptions: it waits several idle cycles after reset before driving anything, and it changes the mode only alongside, or between, advances.

The stimulus covers the cases the assertions are meant to exercise:
- page and array wrap boundaries;
- orphan low-byte loads;
- high and low loads in the same cycle;
- loads colliding with advances.

// File: rtl/wac_pkg.sv
package wac_pkg;
  typedef enum logic {
    WAC_WRITE = 1'b0,
    WAC_READ  = 1'b1
  } wac_mode_e;
endpackage

// File: rtl/wac_rst_sync.sv
module wac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wac_addr_stage.sv
module wac_addr_stage #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [7:0]        byte_in,
  output logic              commit,
  output logic [ADDR_W-1:0] load_addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [HI_W-1:0] hi_q, hi_d;
  logic            pend_q, pend_d;

  // a low byte commits only behind a staged high byte (R6)
  assign commit    = load_lo & pend_q & ~load_hi;
  assign load_addr = {hi_q, byte_in};

  always_comb begin
    hi_d   = hi_q;
    pend_d = pend_q;
    if (load_hi) begin
      hi_d   = byte_in[HI_W-1:0];
      pend_d = 1'b1;
    end else if (commit) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (load_hi) hi_q <= hi_d;
      pend_q <= pend_d;
    end
  end

  assert_commit_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_q);
  assert_hi_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi |=> pend_q);
endmodule

// File: rtl/wac_addr_step.sv
module wac_addr_step #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic [ADDR_W-1:0] cur,
  input  wac_pkg::wac_mode_e mode,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] full_inc;
  assign full_inc = cur + 1'b1;

  generate
    if (PAGE_W >= ADDR_W) begin : g_single_page
      assign nxt = full_inc;
    end else begin : g_paged
      logic [PAGE_W-1:0] ofs_inc;
      assign ofs_inc = cur[PAGE_W-1:0] + 1'b1;
      assign nxt = (mode == wac_pkg::WAC_READ) ? full_inc
                                                : {cur[ADDR_W-1:PAGE_W], ofs_inc};
    end
  endgenerate
endmodule

// File: rtl/wac_top.sv
module wac_top #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [7:0]        byte_in,
  input  logic              step,
  input  logic              rd_mode,
  output logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page_ofs
);
  logic              rst_int_n;
  logic              commit;
  logic [ADDR_W-1:0] load_addr, step_addr;
  logic [ADDR_W-1:0] addr_q, addr_d;
  wac_pkg::wac_mode_e mode;

  assign mode = wac_pkg::wac_mode_e'(rd_mode);

  wac_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  wac_addr_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst_n(rst_int_n), .load_hi(load_hi), .load_lo(load_lo),
    .byte_in(byte_in), .commit(commit), .load_addr(load_addr));

  wac_addr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
    .cur(addr_q), .mode(mode), .nxt(step_addr));

  always_comb begin
    addr_d = addr_q;
    if (commit)    addr_d = load_addr;
    else if (step) addr_d = step_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)          addr_q <= '0;
    else if (commit | step)  addr_q <= addr_d;
  end

  assign addr     = addr_q;
  assign page_ofs = addr_q[PAGE_W-1:0];

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!step && !load_lo) |=> $stable(addr));
  assert_write_page_kept_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && !rd_mode && !load_lo) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
  assert_read_carry_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step && rd_mode && !load_lo) |=> addr == ADDR_W'($past(addr) + 1'b1));
  assert_low_load_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit |=> addr[7:0] == $past(byte_in));
  assert_hi_alone_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (load_hi && !step) |=> $stable(addr));
endmodule

// File: tb/test_wac_top.sv
module test_wac_top;
  localparam int AW = 13;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_hi = 1'b0, load_lo = 1'b0, step = 1'b0, rd_mode = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [AW-1:0] addr;
  logic [PW-1:0] page_ofs;

  int errors = 0;
  int checks = 0;
  int m_addr = 0;
  int m_hi = 0;
  bit m_pend = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wac_top #(.ADDR_W(AW), .PAGE_W(PW)) i_wac_top (
    .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
    .byte_in(byte_in), .step(step), .rd_mode(rd_mode),
    .addr(addr), .page_ofs(page_ofs));

  task automatic check(string req);
    checks++;
    if (int'(addr) != m_addr) begin
      errors++;
      $display("FAIL %s addr actual=%0h expected=%0h", req, addr, m_addr);
    end
    checks++;
    if (int'(page_ofs) != (m_addr % (1 << PW))) begin
      errors++;
      $display("FAIL R8 page_ofs actual=%0h expected=%0h", page_ofs, m_addr % (1 << PW));
    end
  endtask

  // drive at negedge, update model after posedge, compare at next negedge
  task automatic cyc(bit hi, bit lo, bit st, bit rd, logic [7:0] b, string req);
    bit do_commit;
    load_hi = hi; load_lo = lo; step = st; rd_mode = rd; byte_in = b;
    @(posedge clk);
    do_commit = lo && m_pend && !hi;
    if (do_commit) begin
      m_addr = (m_hi << 8) + int'(b);
      m_pend = 1'b0;
    end else if (st) begin
      if (rd) m_addr = (m_addr + 1) % (1 << AW);
      else    m_addr = (m_addr / (1 << PW)) * (1 << PW) + ((m_addr + 1) % (1 << PW));
    end
    if (hi) begin
      m_hi = int'(b) % (1 << (AW - 8));
      m_pend = 1'b1;
    end
    @(negedge clk);
    load_hi = 1'b0; load_lo = 1'b0; step = 1'b0; byte_in = 8'h00;
    check(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1");
    // R6: orphan low byte before any high byte
    cyc(0, 1, 0, 0, 8'h55, "R6");
    // R2: upper bits of high byte ignored
    cyc(1, 0, 0, 0, 8'hFF, "R6");
    cyc(0, 1, 0, 0, 8'hFE, "R2");
    // R3: write wrap inside page
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 8'h00, "R3");
    // R6: second low byte after commit ignored
    cyc(0, 1, 0, 0, 8'h12, "R6");
    // R5: idle hold
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 8'hA5, "R5");
    // R4: read wrap across array end
    cyc(1, 0, 0, 1, 8'h1F, "R6");
    cyc(0, 1, 0, 1, 8'hFD, "R2");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 8'h00, "R4");
    // R4: read carries across page boundary
    cyc(1, 0, 0, 0, 8'h03, "R6");
    cyc(0, 1, 0, 0, 8'h1E, "R2");
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 8'h00, "R4");
    // R6: simultaneous high and low, low ignored
    cyc(1, 1, 0, 0, 8'h0A, "R6");
    // R7: commit beats step
    cyc(0, 1, 1, 0, 8'h9F, "R7");
    // R7: step with high load proceeds
    cyc(1, 0, 1, 0, 8'h01, "R7");
    cyc(0, 1, 1, 1, 8'hFF, "R7");
    cyc(0, 0, 1, 1, 8'h00, "R4");
    cyc(0, 0, 1, 0, 8'h00, "R3");
    // R1: reset clears address
    rst_n = 1'b0;
    m_addr = 0; m_pend = 1'b0;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cyc(0, 1, 0, 0, 8'h77, "R1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule